// File: doc/BRIEF.md
# LCD Pixel Clock and Pin Polarity Controller

This block derives a panel pixel clock from a reference clock by counting clock-enable pulses. A configuration bit picks one of two enable sources: one paced by the video memory bus clock, one paced by the VGA clock. A five-bit divisor field sets the division ratio to the field value plus two, so the ratio runs from 2 to 33. A small state machine walks the high and low phases of each period. A change to the divisor is picked up only when a new period starts, so the pixel clock never glitches.

The same configuration word sets the polarity of the frame-sync pin, the line-sync pin and the AC-bias / output-enable pin, and chooses which pixel-clock edge launches data. The frame, line and data-enable strobes enter active high and leave through one register stage.

In passive display mode the AC-bias pin is a toggle flop. It flips once per programmed number of line-sync rising edges; the programmed value is the wanted count minus one. In active display mode that pin becomes a data-valid enable with programmable polarity. The launch strobe then fires only while the enable is asserted.

Top module: `lcd_pixclk_ctl`

## Requirements
- R1: The configuration word holds the divisor in bits [4:0]. After the first period starts, one pixel-clock period spans exactly divisor+2 selected enable pulses, and `pclk_o` changes only in the cycle after a selected enable pulse.
- R2: Each period holds `pclk_o` high for ceil((divisor+2)/2) enable pulses and low for the remaining floor((divisor+2)/2). `pclk_o` rises in the cycle after the first selected enable pulse that follows reset.
- R3: Configuration bit [5] selects the enable source: 0 uses `ce_dma_i`, 1 uses `ce_vga_i`. Pulses on the unselected enable have no effect on `pclk_o` or `launch_o`.
- R4: A new divisor written while a period is running takes effect from the next rising edge of `pclk_o`. The period in progress completes at its old ratio.
- R5: `frame_pin_o` equals `frame_raw_i` from the previous cycle XOR configuration bit [11] (0 = active high, 1 = active low).
- R6: `line_pin_o` equals `line_raw_i` from the previous cycle XOR configuration bit [12] (0 = active high, 1 = active low).
- R7: `launch_o` is a one-cycle pulse in the same cycle as a `pclk_o` rising edge when configuration bit [13] is 0, or as a falling edge when it is 1. It never fires at any other time.
- R8: With `disp_active_i` low, `ac_pin_o` toggles on every (N+1)-th rising edge of `line_raw_i`, where N is configuration bits [10:6]. A new N takes effect after the next toggle.
- R9: With `disp_active_i` high, `ac_pin_o` equals `de_raw_i` from the previous cycle XOR configuration bit [14] (0 = active high, 1 = active low). `launch_o` is suppressed unless that enable is in its active state.
- R10: While `rst_n` is low, `pclk_o` and `launch_o` are 0, `frame_pin_o` equals bit [11], and `line_pin_o` equals bit [12]. `ac_pin_o` equals bit [14] in active mode and 0 in passive mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 15 | Configuration word (divisor, source, AC-bias count, four polarity bits) |
| disp_active_i | input | 1 | 1 = active display mode, 0 = passive mode |
| ce_dma_i | input | 1 | Clock-enable pulses from the memory bus clock source |
| ce_vga_i | input | 1 | Clock-enable pulses from the VGA clock source |
| frame_raw_i | input | 1 | Raw frame strobe, active high |
| line_raw_i | input | 1 | Raw line strobe, active high |
| de_raw_i | input | 1 | Raw data-enable strobe, active high |
| pclk_o | output | 1 | Divided pixel clock |
| launch_o | output | 1 | Data-launch strobe on the chosen pixel-clock edge |
| frame_pin_o | output | 1 | Conditioned frame-sync pin |
| line_pin_o | output | 1 | Conditioned line-sync pin |
| ac_pin_o | output | 1 | AC-bias toggle (passive) or output enable (active) |

## Verification
A corrupted phase counter or a wrong latched ratio moves a pixel-clock edge. The fault shows on `pclk_o` and `launch_o` within one period, at most 33 selected enable pulses. A fault in the AC-bias line counter stays hidden until the next expected toggle of `ac_pin_o`, so it can take up to 32 line-sync rising edges to show. That is why the sweep runs long enough to cover many line pulses at every count value. Pin register faults show one cycle after the raw strobe changes.

// File: rtl/lcd_pix_pkg.sv
package lcd_pix_pkg;

    // Pixel-clock phase states. Bit 1 of the encoding is the clock level itself.
    typedef enum logic [1:0] {
        PC_IDLE = 2'b00,
        PC_LOW  = 2'b01,
        PC_HIGH = 2'b10
    } pclk_state_e;

    // AC-bias counter states: FRESH uses the live count, RUN uses the latched one.
    typedef enum logic {
        AC_FRESH = 1'b0,
        AC_RUN   = 1'b1
    } acb_state_e;

    typedef struct packed {
        logic inv_oe;
        logic inv_pc;
        logic inv_lp;
        logic inv_fp;
    } pol_t;

endpackage

// File: rtl/lcd_pclk_gen.sv
module lcd_pclk_gen
    import lcd_pix_pkg::*;
#(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             pclk_o,
    output logic             rise_ev_o,
    output logic             fall_ev_o
);

    localparam int RW = DIV_W + 1;

    pclk_state_e     state_q, state_n;
    logic [RW-1:0]   ph_q, ph_n;
    logic [RW-1:0]   ratio_q, ratio_n;
    logic [RW-1:0]   ratio_live;
    logic [RW:0]     hi_len_w;
    logic [RW-1:0]   hi_last, lo_last;

    assign ratio_live = RW'(div_i) + RW'(2);
    assign hi_len_w   = ({1'b0, ratio_q} + (RW+1)'(1)) >> 1;
    assign hi_last    = hi_len_w[RW-1:0] - RW'(1);
    assign lo_last    = (ratio_q >> 1) - RW'(1);

    // Next-state logic
    always_comb begin
        state_n   = state_q;
        ph_n      = ph_q;
        ratio_n   = ratio_q;
        rise_ev_o = 1'b0;
        fall_ev_o = 1'b0;
        unique case (state_q)
            PC_IDLE: begin
                if (tick_i) begin
                    state_n   = PC_HIGH;
                    ph_n      = '0;
                    ratio_n   = ratio_live;
                    rise_ev_o = 1'b1;
                end
            end
            PC_HIGH: begin
                if (tick_i) begin
                    if (ph_q == hi_last) begin
                        state_n   = PC_LOW;
                        ph_n      = '0;
                        fall_ev_o = 1'b1;
                    end else begin
                        ph_n = ph_q + RW'(1);
                    end
                end
            end
            PC_LOW: begin
                if (tick_i) begin
                    if (ph_q == lo_last) begin
                        state_n   = PC_HIGH;
                        ph_n      = '0;
                        ratio_n   = ratio_live;
                        rise_ev_o = 1'b1;
                    end else begin
                        ph_n = ph_q + RW'(1);
                    end
                end
            end
            default: begin
                state_n = PC_IDLE;
                ph_n    = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PC_IDLE;
            ph_q    <= '0;
            ratio_q <= RW'(2);
        end else begin
            state_q <= state_n;
            ph_q    <= ph_n;
            ratio_q <= ratio_n;
        end
    end

    // Output: clock level taken straight from one state flop bit, so it cannot glitch
    always_comb begin
        pclk_o = state_q[1];
    end

endmodule

// File: rtl/lcd_acb_ctr.sv
module lcd_acb_ctr
    import lcd_pix_pkg::*;
#(
    parameter int ACB_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_rise_i,
    input  logic [ACB_W-1:0] acb_i,
    output logic             toggle_o
);

    acb_state_e       state_q, state_n;
    logic [ACB_W-1:0] cnt_q, cnt_n;
    logic [ACB_W-1:0] lim_q, lim_n;
    logic             tog_q, tog_n;
    logic [ACB_W-1:0] lim_use;

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        lim_n   = lim_q;
        tog_n   = tog_q;
        lim_use = lim_q;
        unique case (state_q)
            AC_FRESH: lim_use = acb_i;
            AC_RUN:   lim_use = lim_q;
            default:  lim_use = acb_i;
        endcase
        if (line_rise_i) begin
            if (cnt_q == lim_use) begin
                tog_n   = ~tog_q;
                cnt_n   = '0;
                lim_n   = acb_i;
                state_n = AC_RUN;
            end else begin
                cnt_n = cnt_q + ACB_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= AC_FRESH;
            cnt_q   <= '0;
            lim_q   <= '0;
            tog_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            lim_q   <= lim_n;
            tog_q   <= tog_n;
        end
    end

    always_comb begin
        toggle_o = tog_q;
    end

endmodule

// File: rtl/lcd_pin_cond.sv
module lcd_pin_cond
    import lcd_pix_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  pol_t pol_i,
    input  logic act_i,
    input  logic frame_raw_i,
    input  logic line_raw_i,
    input  logic de_raw_i,
    input  logic rise_ev_i,
    input  logic fall_ev_i,
    input  logic acb_tog_i,
    output logic line_rise_o,
    output logic frame_pin_o,
    output logic line_pin_o,
    output logic ac_pin_o,
    output logic launch_o
);

    logic fp_q, lp_q, de_q, launch_q;
    logic launch_d;

    // Launch on the chosen edge, gated by the data enable in active mode
    assign launch_d    = (pol_i.inv_pc ? fall_ev_i : rise_ev_i) && (!act_i || de_raw_i);
    assign line_rise_o = line_raw_i && !lp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fp_q     <= 1'b0;
            lp_q     <= 1'b0;
            de_q     <= 1'b0;
            launch_q <= 1'b0;
        end else begin
            fp_q     <= frame_raw_i;
            lp_q     <= line_raw_i;
            de_q     <= de_raw_i;
            launch_q <= launch_d;
        end
    end

    always_comb begin
        frame_pin_o = fp_q ^ pol_i.inv_fp;
        line_pin_o  = lp_q ^ pol_i.inv_lp;
        ac_pin_o    = act_i ? (de_q ^ pol_i.inv_oe) : acb_tog_i;
        launch_o    = launch_q;
    end

endmodule

// File: rtl/lcd_pixclk_ctl.sv
module lcd_pixclk_ctl
    import lcd_pix_pkg::*;
#(
    parameter int DIV_W = 5,
    parameter int ACB_W = 5,
    localparam int SRC_BIT = DIV_W,
    localparam int ACB_LSB = DIV_W + 1,
    localparam int IFP_BIT = ACB_LSB + ACB_W,
    localparam int ILP_BIT = IFP_BIT + 1,
    localparam int IPC_BIT = IFP_BIT + 2,
    localparam int IOE_BIT = IFP_BIT + 3,
    localparam int CFG_W   = IOE_BIT + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             disp_active_i,
    input  logic             ce_dma_i,
    input  logic             ce_vga_i,
    input  logic             frame_raw_i,
    input  logic             line_raw_i,
    input  logic             de_raw_i,
    output logic             pclk_o,
    output logic             launch_o,
    output logic             frame_pin_o,
    output logic             line_pin_o,
    output logic             ac_pin_o
);

    logic tick;
    logic rise_ev, fall_ev;
    logic line_rise;
    logic acb_tog;
    pol_t pol;

    assign tick       = cfg_i[SRC_BIT] ? ce_vga_i : ce_dma_i;
    assign pol.inv_fp = cfg_i[IFP_BIT];
    assign pol.inv_lp = cfg_i[ILP_BIT];
    assign pol.inv_pc = cfg_i[IPC_BIT];
    assign pol.inv_oe = cfg_i[IOE_BIT];

    lcd_pclk_gen #(.DIV_W(DIV_W)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .div_i     (cfg_i[DIV_W-1:0]),
        .pclk_o    (pclk_o),
        .rise_ev_o (rise_ev),
        .fall_ev_o (fall_ev)
    );

    lcd_acb_ctr #(.ACB_W(ACB_W)) u_acb (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_rise_i (line_rise),
        .acb_i       (cfg_i[ACB_LSB +: ACB_W]),
        .toggle_o    (acb_tog)
    );

    lcd_pin_cond u_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .pol_i       (pol),
        .act_i       (disp_active_i),
        .frame_raw_i (frame_raw_i),
        .line_raw_i  (line_raw_i),
        .de_raw_i    (de_raw_i),
        .rise_ev_i   (rise_ev),
        .fall_ev_i   (fall_ev),
        .acb_tog_i   (acb_tog),
        .line_rise_o (line_rise),
        .frame_pin_o (frame_pin_o),
        .line_pin_o  (line_pin_o),
        .ac_pin_o    (ac_pin_o),
        .launch_o    (launch_o)
    );

endmodule

// File: rtl/lcd_pixclk_ctl_chk.sv
module lcd_pixclk_ctl_chk (
    input logic clk,
    input logic rst_n,
    input logic sel,
    input logic inv_fp,
    input logic inv_lp,
    input logic inv_pc,
    input logic inv_oe,
    input logic disp_active_i,
    input logic ce_dma_i,
    input logic ce_vga_i,
    input logic frame_raw_i,
    input logic line_raw_i,
    input logic pclk_o,
    input logic launch_o,
    input logic frame_pin_o,
    input logic line_pin_o,
    input logic ac_pin_o
);

    logic sel_tick;
    assign sel_tick = sel ? ce_vga_i : ce_dma_i;

    AST_PCLK_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_tick |=> $stable(pclk_o)); // R3

    AST_LAUNCH_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |-> (pclk_o != $past(pclk_o))); // R7

    AST_LAUNCH_EDGE_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |-> (pclk_o == !$past(inv_pc))); // R7

    AST_FRAME_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (frame_pin_o == ($past(frame_raw_i) ^ inv_fp))); // R5

    AST_LINE_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (line_pin_o == ($past(line_raw_i) ^ inv_lp))); // R6

    AST_OE_GATES_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_o && disp_active_i && $past(disp_active_i)) |-> (ac_pin_o != inv_oe)); // R9

    AST_ACB_TOGGLE_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_active_i && $past(!disp_active_i) && (ac_pin_o != $past(ac_pin_o)))
            |-> $past(line_raw_i)); // R8

endmodule

bind lcd_pixclk_ctl lcd_pixclk_ctl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel           (cfg_i[SRC_BIT]),
    .inv_fp        (cfg_i[IFP_BIT]),
    .inv_lp        (cfg_i[ILP_BIT]),
    .inv_pc        (cfg_i[IPC_BIT]),
    .inv_oe        (cfg_i[IOE_BIT]),
    .disp_active_i (disp_active_i),
    .ce_dma_i      (ce_dma_i),
    .ce_vga_i      (ce_vga_i),
    .frame_raw_i   (frame_raw_i),
    .line_raw_i    (line_raw_i),
    .pclk_o        (pclk_o),
    .launch_o      (launch_o),
    .frame_pin_o   (frame_pin_o),
    .line_pin_o    (line_pin_o),
    .ac_pin_o      (ac_pin_o)
);

// File: tb/lcd_pixclk_ctl_tb.sv
module lcd_pixclk_ctl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [14:0] cfg;
    logic        act, ce_dma, ce_vga, fr, ln, de;
    logic        pclk, launch, frame_pin, line_pin, ac_pin;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;
    string pclk_tag;

    // model state
    bit started, acb_st, ac_started, prev_line;
    int pos, ncur, lcnt, lim;
    bit fr_e, ln_e, de_e, exp_launch;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_pixclk_ctl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_i         (cfg),
        .disp_active_i (act),
        .ce_dma_i      (ce_dma),
        .ce_vga_i      (ce_vga),
        .frame_raw_i   (fr),
        .line_raw_i    (ln),
        .de_raw_i      (de),
        .pclk_o        (pclk),
        .launch_o      (launch),
        .frame_pin_o   (frame_pin),
        .line_pin_o    (line_pin),
        .ac_pin_o      (ac_pin)
    );

    function automatic logic [14:0] mk_cfg(int dv, bit sl, int ab, bit ifp, bit ilp, bit ipc, bit ioe);
        return {ioe, ipc, ilp, ifp, 5'(ab), sl, 5'(dv)};
    endfunction

    task automatic chk(bit ok, string tag, string name, logic a, logic e);
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, name, a, e, $time);
        end
    endtask

    task automatic model_reset();
        started = 0; pos = 0; ncur = 2;
        acb_st = 0; ac_started = 0; lcnt = 0; lim = 0; prev_line = 0;
        fr_e = 0; ln_e = 0; de_e = 0; exp_launch = 0;
    endtask

    // R10: reset state
    task automatic do_reset(logic [14:0] c, bit a);
        rst_n = 1'b0; cfg = c; act = a;
        ce_dma = 0; ce_vga = 0; fr = 0; ln = 0; de = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        vectors++;
        chk(pclk == 1'b0, "R10", "pclk", pclk, 1'b0);
        chk(launch == 1'b0, "R10", "launch", launch, 1'b0);
        chk(frame_pin == c[11], "R10", "frame_pin", frame_pin, c[11]);
        chk(line_pin == c[12], "R10", "line_pin", line_pin, c[12]);
        chk(ac_pin == (a ? c[14] : 1'b0), "R10", "ac_pin", ac_pin, a ? c[14] : 1'b0);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic drive_rand();
        ce_dma = ($urandom % 3) != 0;
        ce_vga = ($urandom % 3) != 1;
        fr     = ($urandom % 5) == 0;
        ln     = ($urandom % 3) == 0;
        de     = ($urandom % 2) == 0;
    endtask

    task automatic step();
        bit tick, rise, ev_r, ev_f;
        int hi, lim_use;
        logic exp_pclk, exp_ac;
        tick = cfg[5] ? ce_vga : ce_dma;
        @(posedge clk);
        // divider model (R1 R2 R4)
        ev_r = 0; ev_f = 0;
        if (tick) begin
            if (!started) begin
                started = 1; pos = 0; ncur = int'(cfg[4:0]) + 2; ev_r = 1;
            end else begin
                pos++;
                if (pos == ncur) begin pos = 0; ncur = int'(cfg[4:0]) + 2; ev_r = 1; end
            end
        end
        hi = (ncur + 1) / 2;
        if (tick && started && pos == hi) ev_f = 1;
        exp_launch = (cfg[13] ? ev_f : ev_r) && (!act || de);
        // AC-bias model (R8)
        rise = ln && !prev_line;
        prev_line = ln;
        if (rise) begin
            lim_use = ac_started ? lim : int'(cfg[10:6]);
            if (lcnt == lim_use) begin
                acb_st = !acb_st; lcnt = 0; lim = int'(cfg[10:6]); ac_started = 1;
            end else lcnt++;
        end
        fr_e = fr; ln_e = ln; de_e = de;
        @(negedge clk);
        vectors++;
        exp_pclk = started && (pos < hi);
        exp_ac   = act ? (de_e ^ cfg[14]) : acb_st;
        chk(pclk == exp_pclk, pclk_tag, "pclk", pclk, exp_pclk);
        chk(launch == exp_launch, act ? "R7 R9" : "R7", "launch", launch, exp_launch);
        chk(frame_pin == (fr_e ^ cfg[11]), "R5", "frame_pin", frame_pin, fr_e ^ cfg[11]);
        chk(line_pin == (ln_e ^ cfg[12]), "R6", "line_pin", line_pin, ln_e ^ cfg[12]);
        chk(ac_pin == exp_ac, act ? "R9" : "R8", "ac_pin", ac_pin, exp_ac);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0;
        pclk_tag = "R1 R2 R3";
        // Sweep every divisor with both sources, mixed polarities and modes
        for (int d = 0; d < 32; d++) begin
            for (int s = 0; s < 2; s++) begin
                int pol = (d + s * 5) % 16;
                do_reset(mk_cfg(d, s[0], (d * 7 + s * 3) % 32,
                                pol[0], pol[1], pol[2], pol[3]), d[1] ^ s[0]);
                for (int n = 0; n < 300; n++) begin
                    drive_rand();
                    step();
                end
            end
        end
        // Passive AC-bias: dense line pulses at small counts
        for (int ab = 0; ab < 4; ab++) begin
            do_reset(mk_cfg(1, 0, ab, 0, 0, 1, 0), 1'b0);
            for (int n = 0; n < 200; n++) begin
                drive_rand();
                ln = n[0];
                step();
            end
        end
        // R4: divisor and AC count changes mid-period
        pclk_tag = "R4";
        do_reset(mk_cfg(3, 0, 2, 0, 1, 0, 0), 1'b0);
        for (int n = 0; n < 61; n++) begin drive_rand(); step(); end
        cfg = mk_cfg(12, 0, 5, 0, 1, 0, 0);
        for (int n = 0; n < 200; n++) begin drive_rand(); step(); end
        cfg = mk_cfg(0, 0, 1, 0, 1, 0, 0);
        for (int n = 0; n < 120; n++) begin drive_rand(); step(); end
        cfg = mk_cfg(31, 0, 0, 0, 1, 0, 0);
        for (int n = 0; n < 200; n++) begin drive_rand(); step(); end
        finish_run();
    end

endmodule